// File: doc/BRIEF.md
# Counter-Compare Watchdog Timer

This block is a watchdog built around a free-running 16-bit count split into a low byte and a high byte. The count advances on a strobe taken from the system clock through a selectable divider, and only while the count enable input is high. Software services the watchdog by writing a kick register. The kick loads a compare byte with the current high byte plus a programmed offset. A one-cycle reset pulse goes out when the low byte rolls over while the high byte equals the compare byte, or at once when software writes the force bit while the watchdog is armed.

The watchdog is armed when the enable bit or the sticky lock bit is set. While it is armed, the clock divider choice and the idle-suspend choice cannot be changed. With idle suspend set, the count halts whenever the idle input is high. The reset pulse returns every register in the block to its power-on value, including the lock bit. In that state the watchdog is armed and divides by 12, so the next timeout comes 3072 system clocks later.

Top module: `cmp_watchdog`

## Requirements
- R1: After reset (asynchronous or a watchdog pulse) the block is armed, divides by 12, and has count, offset and compare all at zero. With the count enable held high, the first pulse appears 3072 system clocks after reset release.
- R2: `wdt_rst_o` goes high for exactly one cycle, one clock after a counter strobe in which the low byte is 0xFF, the high byte equals the compare byte and the block is armed.
- R3: A write to address 2 (data ignored) loads the compare byte with the current high byte plus the offset held at address 1, modulo 256. With L the low byte at the kick, the pulse follows 256*offset + 256 - L counter strobes.
- R4: A write to address 3 with data bit 0 set raises the pulse on the next clock if the block is armed. When the block is not armed, the write has no effect.
- R5: Control register (address 0) bit 0 is enable and bit 1 is lock. The block is armed when either bit is set. Lock can only be set by software and survives later writes. When lock is clear, writing enable as 0 disarms the block and no pulse is produced.
- R6: Control writes to the clock select (bits 3:2) and the idle suspend bit (bit 4) take effect only if the block was not armed before the write.
- R7: Clock select 0 strobes the counter every 12 system clocks, 1 every 4, and 2 or 3 on every clock.
- R8: The count holds when `cnt_en_i` is low, or when idle suspend is set and `idle_i` is high.
- R9: The reset pulse clears the lock bit and returns every register to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable for the prescaled counter |
| idle_i | input | 1 | Idle indication; halts the count when idle suspend is set |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 offset, 2 kick, 3 force |
| wr_data_i | input | 8 | Register write data |
| wdt_rst_o | output | 1 | Watchdog reset pulse, one clock wide |

## Verification
On every clock the assertions check that the pulse is one cycle wide and returns the registers to their defaults. They also check that lock stays set, that the clock and idle settings do not move while the block is armed, that an armed force write always produces a pulse, and that the count freezes whenever it is gated. Only the bench scenarios can show the exact timeout lengths:
- the 3072-clock default interval,
- the offset/low-byte formula,
- the divide-by-4 and undivided rates,
- a compare byte that wraps past 0xFF,
- the pulse that resumes once idle ends.

A per-cycle reference model in the bench also compares the pulse under random register traffic.

// File: rtl/cmp_wdt_pkg.sv
package cmp_wdt_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_OFFS  = 2'd1,
    REG_KICK  = 2'd2,
    REG_FORCE = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    CLK_DIV_SLOW = 2'd0,
    CLK_DIV_MID  = 2'd1,
    CLK_DIV_NONE = 2'd2,
    CLK_DIV_ALT  = 2'd3
  } clk_sel_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_LOCK_BIT = 1;
  localparam int unsigned CTRL_SEL_LSB  = 2;
  localparam int unsigned CTRL_IDLE_BIT = 4;
  localparam int unsigned FORCE_BIT     = 0;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import cmp_wdt_pkg::*;
#(
  parameter int unsigned DIV_SLOW = 12,
  parameter int unsigned DIV_MID  = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     run_i,
  input  clk_sel_e sel_i,
  output logic     tick_o
);
  localparam int unsigned PW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  always_comb begin
    unique case (sel_i)
      CLK_DIV_SLOW: lim = PW'(DIV_SLOW - 1);
      CLK_DIV_MID:  lim = PW'(DIV_MID - 1);
      default:      lim = '0;
    endcase
  end

  // >= so a shrinking divisor never strands the count above the limit
  assign tick_o = run_i && (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else if (run_i)  pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_split_counter.sv
module wdt_split_counter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              lo_wrap_o
);
  localparam int unsigned CW = 2 * BYTE_W;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign lo_o      = cnt_q[BYTE_W-1:0];
  assign hi_o      = cnt_q[CW-1:BYTE_W];
  assign lo_wrap_o = tick_i && (&lo_o);
endmodule

// File: rtl/cmp_watchdog.sv
module cmp_watchdog
  import cmp_wdt_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned DIV_SLOW = 12,
  parameter int unsigned DIV_MID  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              idle_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              wdt_rst_o
);
  logic              en_q, lock_q, idle_sus_q, rst_q;
  clk_sel_e          sel_q;
  logic [BYTE_W-1:0] offs_q, cmp_q;
  logic [BYTE_W-1:0] lo, hi;
  logic              tick, lo_wrap, run, armed;
  logic              wr_ctrl, wr_offs, wr_kick, wr_force;
  logic              force_hit, timeout_hit;

  assign armed = en_q | lock_q;
  assign run   = cnt_en_i & ~(idle_sus_q & idle_i);

  wdt_prescale #(
    .DIV_SLOW(DIV_SLOW),
    .DIV_MID (DIV_MID)
  ) i_prescale (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rst_q),
    .run_i (run),
    .sel_i (sel_q),
    .tick_o(tick)
  );

  wdt_split_counter #(
    .BYTE_W(BYTE_W)
  ) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rst_q),
    .tick_i   (tick),
    .lo_o     (lo),
    .hi_o     (hi),
    .lo_wrap_o(lo_wrap)
  );

  assign wr_ctrl  = wr_en_i && (wr_addr_i == REG_CTRL);
  assign wr_offs  = wr_en_i && (wr_addr_i == REG_OFFS);
  assign wr_kick  = wr_en_i && (wr_addr_i == REG_KICK);
  assign wr_force = wr_en_i && (wr_addr_i == REG_FORCE);

  assign force_hit   = wr_force && wr_data_i[FORCE_BIT] && armed;
  assign timeout_hit = lo_wrap && (hi == cmp_q) && armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b1;
      lock_q     <= 1'b0;
      idle_sus_q <= 1'b0;
      sel_q      <= CLK_DIV_SLOW;
      offs_q     <= '0;
      cmp_q      <= '0;
      rst_q      <= 1'b0;
    end else if (rst_q) begin
      // own pulse restores defaults, lock included
      en_q       <= 1'b1;
      lock_q     <= 1'b0;
      idle_sus_q <= 1'b0;
      sel_q      <= CLK_DIV_SLOW;
      offs_q     <= '0;
      cmp_q      <= '0;
      rst_q      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wr_data_i[CTRL_EN_BIT];
        lock_q <= lock_q | wr_data_i[CTRL_LOCK_BIT];
        if (!armed) begin
          sel_q      <= clk_sel_e'(wr_data_i[CTRL_SEL_LSB +: 2]);
          idle_sus_q <= wr_data_i[CTRL_IDLE_BIT];
        end
      end
      if (wr_offs) offs_q <= wr_data_i;
      if (wr_kick) cmp_q  <= hi + offs_q;
      rst_q <= force_hit | timeout_hit;
    end
  end

  assign wdt_rst_o = rst_q;
endmodule

// File: rtl/cmp_watchdog_chk.sv
module cmp_watchdog_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cnt_en_i,
  input logic              idle_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [BYTE_W-1:0] wr_data_i,
  input logic              wdt_rst_o,
  input logic              en_q,
  input logic              lock_q,
  input logic              idle_sus_q,
  input logic [1:0]        sel_q,
  input logic [BYTE_W-1:0] offs_q,
  input logic [BYTE_W-1:0] lo,
  input logic [BYTE_W-1:0] hi
);
  assert_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);

  assert_defaults_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> (en_q && !lock_q && !idle_sus_q && sel_q == 2'd0 &&
                   offs_q == '0 && lo == '0 && hi == '0));

  assert_lock_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !wdt_rst_o) |=> lock_q);

  assert_disarmed_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_q || lock_q) |=> !wdt_rst_o);

  assert_cfg_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_q || lock_q) && !wdt_rst_o) |=> ($stable(sel_q) && $stable(idle_sus_q)));

  assert_force_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd3 && wr_data_i[0] && (en_q || lock_q) && !wdt_rst_o)
      |=> wdt_rst_o);

  assert_count_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!cnt_en_i || (idle_sus_q && idle_i)) && !wdt_rst_o) |=> ($stable(lo) && $stable(hi)));
endmodule

bind cmp_watchdog cmp_watchdog_chk #(.BYTE_W(BYTE_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_en_i  (cnt_en_i),
  .idle_i    (idle_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .wdt_rst_o (wdt_rst_o),
  .en_q      (en_q),
  .lock_q    (lock_q),
  .idle_sus_q(idle_sus_q),
  .sel_q     (sel_q),
  .offs_q    (offs_q),
  .lo        (lo),
  .hi        (hi)
);

// File: tb/test_cmp_watchdog.sv
`timescale 1ns/1ps
module test_cmp_watchdog;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cnt_en = 1'b0;
  logic       idle = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       wdt_rst;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_watchdog i_cmp_watchdog (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .cnt_en_i (cnt_en),
    .idle_i   (idle),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .wdt_rst_o(wdt_rst)
  );

  // reference model built from the requirements
  int       m_pre;
  bit [15:0] m_cnt;
  bit [7:0] m_cmp, m_off;
  bit       m_en, m_lock, m_isus, m_rst;
  bit [1:0] m_sel;
  int       v_div;
  bit       v_run, v_tick, v_arm, v_fire;

  task automatic m_defaults();
    m_pre = 0; m_cnt = '0; m_cmp = '0; m_off = '0;
    m_en = 1'b1; m_lock = 1'b0; m_isus = 1'b0; m_sel = 2'd0; m_rst = 1'b0;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) m_defaults();
    else if (m_rst) m_defaults();
    else begin
      v_div  = (m_sel == 2'd0) ? 12 : (m_sel == 2'd1) ? 4 : 1;
      v_arm  = m_en | m_lock;
      v_run  = cnt_en && !(m_isus && idle);
      v_tick = v_run && (m_pre >= v_div - 1);
      v_fire = (v_tick && m_cnt[7:0] == 8'hFF && m_cnt[15:8] == m_cmp && v_arm) ||
               (wr_en && wr_addr == 2'd3 && wr_data[0] && v_arm);
      if (wr_en && wr_addr == 2'd2) m_cmp = m_cnt[15:8] + m_off;
      if (wr_en && wr_addr == 2'd1) m_off = wr_data;
      if (wr_en && wr_addr == 2'd0) begin
        if (!v_arm) begin m_sel = wr_data[3:2]; m_isus = wr_data[4]; end
        m_en = wr_data[0];
        m_lock = m_lock | wr_data[1];
      end
      if (v_tick) begin m_pre = 0; m_cnt = m_cnt + 16'd1; end
      else if (v_run) m_pre = m_pre + 1;
      m_rst = v_fire;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R2)
  always @(negedge clk) if (rst_ni && !done)
    chk(wdt_rst === m_rst, "R2 pulse vs model", int'(wdt_rst), int'(m_rst));

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // run counter until pulse, then freeze; returns posedges counted
  task automatic run_until(input int maxc, output int cyc);
    cyc = 0;
    cnt_en = 1'b1;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (wdt_rst) begin cnt_en = 1'b0; break; end
      if (cyc > maxc) begin cnt_en = 1'b0; cyc = -1; break; end
    end
  endtask

  task automatic advance(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    chk(1'b0, "watchdog expired", 0, 1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    bit quiet;
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);

    repeat (3) @(negedge clk);
    chk(wdt_rst == 1'b0, "R1 output low in reset", int'(wdt_rst), 0);
    cnt_en = 1'b1;
    rst_ni = 1'b1;
    run_until(5000, cyc);
    chk(cyc == 3072, "R1 default timeout", cyc, 3072);

    // R6: clock select write ignored while armed
    wr(2'd0, 8'h09);
    wr(2'd2, 8'h00);
    run_until(5000, cyc);
    chk(cyc == 3072, "R6 select ignored when armed", cyc, 3072);

    // R3/R7: undivided, offset 2, low byte 37 at kick
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h09);
    wr(2'd1, 8'd2);
    advance(37);
    wr(2'd2, 8'h00);
    run_until(5000, cyc);
    chk(cyc == 731, "R3 offset formula", cyc, 731);

    // R7 divide by 4
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h05);
    wr(2'd2, 8'h00);
    run_until(5000, cyc);
    chk(cyc == 1024, "R7 divide by four", cyc, 1024);

    // R3 compare byte wraps: high=2, offset 254 -> compare 0
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h09);
    wr(2'd1, 8'd255);
    wr(2'd2, 8'h00);
    advance(522);
    chk(wdt_rst == 1'b0, "R3 no early pulse", int'(wdt_rst), 0);
    wr(2'd1, 8'd254);
    wr(2'd2, 8'h00);
    run_until(70000, cyc);
    chk(cyc == 65270, "R3 wrapped compare", cyc, 65270);

    // R5: lock keeps it armed with enable cleared
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h00);
    run_until(5000, cyc);
    chk(cyc == 3072, "R5 lock keeps armed", cyc, 3072);

    // R9: lock cleared by pulse, so disarm works; R4 force ignored
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h01);
    chk(wdt_rst == 1'b0, "R4 force ignored when disarmed", int'(wdt_rst), 0);
    @(negedge clk);
    chk(wdt_rst == 1'b0, "R9 lock cleared, still disarmed", int'(wdt_rst), 0);
    quiet = 1'b1;
    cnt_en = 1'b1;
    repeat (3200) begin @(negedge clk); if (wdt_rst) quiet = 1'b0; end
    cnt_en = 1'b0;
    chk(quiet, "R5 disarmed gives no timeout", int'(quiet), 1);

    // R8: idle suspend freezes; low=10 high=1 -> 246 strobes left
    wr(2'd0, 8'h18);
    wr(2'd0, 8'h19);
    wr(2'd2, 8'h00);
    idle = 1'b1;
    quiet = 1'b1;
    cnt_en = 1'b1;
    repeat (500) begin @(negedge clk); if (wdt_rst) quiet = 1'b0; end
    chk(quiet, "R8 idle holds count", int'(quiet), 1);
    idle = 1'b0;
    run_until(5000, cyc);
    chk(cyc == 246, "R8 resume after idle", cyc, 246);

    // R4 armed force gives pulse next clock
    wr(2'd3, 8'h01);
    chk(wdt_rst == 1'b1, "R4 force pulse", int'(wdt_rst), 1);
    @(negedge clk);
    chk(wdt_rst == 1'b0, "R2 single cycle", int'(wdt_rst), 0);

    // random traffic checked by the model
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      cnt_en  = ($urandom_range(0, 9) != 0);
      idle    = ($urandom_range(0, 3) == 0);
      wr_en   = ($urandom_range(0, 4) == 0);
      wr_addr = 2'($urandom_range(0, 3));
      wr_data = 8'($urandom_range(0, 255));
      if (wr_addr == 2'd3 && $urandom_range(0, 7) != 0) wr_data[0] = 1'b0;
      if (wr_addr == 2'd0 && $urandom_range(0, 3) != 0) wr_data[1] = 1'b0;
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule